// File: doc/BRIEF.md
# Third-Order Three-Level Digital Noise-Shaping Modulator

The block turns a slow stream of 16-bit audio samples into a fast stream of three-level codes (−1, 0, +1). The noise that this coarse rounding introduces is pushed above the audio band. A new sample arrives at the base rate of 40 kHz. The block holds it and runs its loop once per enabled modulator clock, nominally 64 times per sample (2.56 MHz). A downstream three-level converter turns the codes back into a signal.

The loop uses three cascaded registered integrators. Each integrator is fed the difference between its input and the quantised output, weighted by a power of two (1/4, 1/4 and 1), so every gain is a plain shift. The full-scale feedback level equals a full-scale input: +1 stands for +32768 input units and −1 for −32768. Because of this, the long-run mean of the output levels follows the input. All state is 19 bits wide and saturates at the signed 19-bit limits.

Top module: `tri_sdm3`

## Requirements
- R1: A synchronous reset clears the three integrators and the held sample, and the output reads 2'b00 on the first edge after reset is applied.
- R2: When `smp_ld` is high at an edge, `smp_in` becomes the held sample at that edge. Loop updates at that same edge still use the previous held sample. The held value stays until the next load.
- R3: Integrator state and `code_out` change only at edges where `en` is high. Edges with `en` low leave `code_out` unchanged.
- R4: `code_out` encodes the level: 2'b01 means +1, 2'b00 means 0 and 2'b11 means −1. The value 2'b10 never appears.
- R5: The quantiser reads the third integrator `s3`. It gives +1 when s3 ≥ 16384, −1 when s3 ≤ −16384, and 0 otherwise.
- R6: With `f` = level × 32768, one enabled edge computes the new values from the old ones: s1 += (x − f) >>> 2, s2 += (s1 − f) >>> 2, s3 += (s2 − f). Here x is the sign-extended held sample and >>> is an arithmetic shift with floor rounding.
- R7: Each integrator update saturates to the range [−262144, 262143] instead of wrapping.
- R8: For a constant input held over 4096 enabled edges after reset, the mean output level times 32768 lies within 1024 of the input, down to the full-scale value −32768.
- R9: A sine input at −6 dBFS (amplitude 16384) keeps every integrator inside its limits and the output on the three legal codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Loop-rate clock enable |
| smp_in | input | 16 | Signed input sample |
| smp_ld | input | 1 | Captures `smp_in` as the held sample |
| code_out | output | 2 | Three-level output code |

## Verification
The output code is a direct function of the third integrator. A wrong update in that stage therefore shows at the ports on the very next enabled edge. An error in the first or second stage shows only after it has passed through the later stages, which takes one or two more enabled edges. A wrong feedback weight or a slip in sample timing may first show only as drift in the code pattern. For that reason the bench compares every cycle against its own recursion, and it also checks long-run mean levels for DC inputs.

// File: rtl/tri_sdm3.sv
module tri_sdm3 #(
  parameter int IN_W = 16,
  parameter int ST_W = 19
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [IN_W-1:0] smp_in,
  input  logic            smp_ld,
  output logic [1:0]      code_out
);
  localparam int X_W = ST_W + 2;
  localparam logic signed [X_W-1:0] FS   = X_W'(1 << (IN_W - 1));
  localparam logic signed [X_W-1:0] HALF = X_W'(1 << (IN_W - 2));
  localparam logic signed [X_W-1:0] SMAX = X_W'((1 << (ST_W - 1)) - 1);
  localparam logic signed [X_W-1:0] SMIN = -X_W'(1 << (ST_W - 1));

  logic signed [IN_W-1:0] held;
  logic signed [ST_W-1:0] s1, s2, s3;
  logic signed [X_W-1:0]  xe, e1, e2, e3, fb, n1, n2, n3;

  function automatic logic signed [ST_W-1:0] clip(input logic signed [X_W-1:0] v);
    if (v > SMAX)      return SMAX[ST_W-1:0];
    else if (v < SMIN) return SMIN[ST_W-1:0];
    else               return v[ST_W-1:0];
  endfunction

  assign xe = X_W'(held);
  assign e1 = X_W'(s1);
  assign e2 = X_W'(s2);
  assign e3 = X_W'(s3);

  assign code_out = (e3 >= HALF) ? 2'b01 : (e3 <= -HALF) ? 2'b11 : 2'b00;
  assign fb = (code_out == 2'b01) ? FS : (code_out == 2'b11) ? -FS : '0;

  assign n1 = e1 + ((xe - fb) >>> 2);
  assign n2 = e2 + ((e1 - fb) >>> 2);
  assign n3 = e3 + (e2 - fb);

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      s1   <= '0;
      s2   <= '0;
      s3   <= '0;
    end else begin
      if (smp_ld) held <= smp_in;
      if (en) begin
        s1 <= clip(n1);
        s2 <= clip(n2);
        s3 <= clip(n3);
      end
    end
  end
endmodule

// File: rtl/tri_sdm3_chk.sv
module tri_sdm3_chk #(
  parameter int IN_W = 16,
  parameter int ST_W = 19
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   en,
  input logic                   smp_ld,
  input logic [IN_W-1:0]        smp_in,
  input logic [1:0]             code_out,
  input logic signed [IN_W-1:0] held,
  input logic signed [ST_W-1:0] s1
);
  a_r4_legal_code: assert property (@(posedge clk) disable iff (rst)
    code_out != 2'b10);

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> code_out == 2'b00);

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(code_out));

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    smp_ld |=> held == $past(smp_in));

  a_r6_pos_pulls_down: assert property (@(posedge clk) disable iff (rst)
    (en && code_out == 2'b01) |=> s1 <= $past(s1));

  a_r6_neg_pulls_up: assert property (@(posedge clk) disable iff (rst)
    (en && code_out == 2'b11) |=> s1 >= $past(s1));
endmodule

bind tri_sdm3 tri_sdm3_chk #(.IN_W(IN_W), .ST_W(ST_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .smp_ld(smp_ld), .smp_in(smp_in),
  .code_out(code_out), .held(held), .s1(s1)
);

// File: tb/tri_sdm3_bench.sv
module tri_sdm3_bench;
  localparam int CLK_P = 10;
  localparam longint FSV = 32768;
  localparam longint LMAX = 262143;
  localparam longint LMIN = -262144;

  logic clk = 0;
  logic rst = 1;
  logic en = 0;
  logic smp_ld = 0;
  logic [15:0] smp_in = '0;
  logic [1:0] code_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit sat_hit = 0;
  longint m1 = 0, m2 = 0, m3 = 0, mh = 0;

  always #(CLK_P/2) clk = ~clk;

  tri_sdm3 u_tri_sdm3 (.clk(clk), .rst(rst), .en(en), .smp_in(smp_in),
                       .smp_ld(smp_ld), .code_out(code_out));

  function automatic int lvl_of(input longint s);
    if (s >= FSV/2) return 1;
    if (s <= -FSV/2) return -1;
    return 0;
  endfunction

  function automatic logic [1:0] enc(input int l);
    return (l == 1) ? 2'b01 : (l == -1) ? 2'b11 : 2'b00;
  endfunction

  function automatic int dec(input logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b11) ? -1 : 0;
  endfunction

  function automatic longint lim(input longint v);
    if (v > LMAX) begin sat_hit = 1; return LMAX; end
    if (v < LMIN) begin sat_hit = 1; return LMIN; end
    return v;
  endfunction

  task automatic model_edge();
    longint f, n1, n2, n3;
    if (rst) begin
      m1 = 0; m2 = 0; m3 = 0; mh = 0;
    end else begin
      f = lvl_of(m3) * FSV;
      n1 = lim(m1 + ((mh - f) >>> 2));
      n2 = lim(m2 + ((m1 - f) >>> 2));
      n3 = lim(m3 + (m2 - f));
      if (en) begin m1 = n1; m2 = n2; m3 = n3; end
      if (smp_ld) mh = longint'($signed(smp_in));
    end
  endtask

  task automatic cyc(input bit e, input bit l, input logic [15:0] d, input string tag);
    logic [1:0] exp_c;
    en = e; smp_ld = l; smp_in = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    exp_c = enc(lvl_of(m3));
    checks++;
    if (code_out !== exp_c || code_out == 2'b10) begin
      errors++;
      if (errors < 20)
        $display("FAIL %s: code_out got %b expected %b", tag, code_out, exp_c);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    cyc(1'b0, 1'b0, 16'h0, "R1");
    rst = 0;
  endtask

  task automatic dc_run(input int x);
    longint sum = 0;
    longint meanv;
    do_reset();
    cyc(1'b0, 1'b1, 16'(x), "R2");
    for (int k = 0; k < 4096; k++) begin
      cyc(1'b1, 1'b0, 16'(x), "R5/R6");
      sum += dec(code_out);
    end
    meanv = sum * 8;
    checks++;
    if (meanv - x > 1024 || x - meanv > 1024) begin
      errors++;
      $display("FAIL R8: mean level*32768 got %0d expected %0d", meanv, x);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();
    checks++;
    if (code_out !== 2'b00) begin
      errors++;
      $display("FAIL R1: code_out after reset got %b expected 00", code_out);
    end

    dc_run(0);
    dc_run(9000);
    dc_run(-14000);
    dc_run(24000);
    dc_run(-32768);

    for (int k = 0; k < 16000; k++)
      cyc(($urandom % 4) != 0, ($urandom % 8) == 0, 16'($urandom), "R3");

    for (int k = 0; k < 2000; k++)
      cyc(k[0], 1'b1, 16'($urandom), "R2");

    for (int k = 0; k < 8192; k++)
      cyc(1'b1, (k % 64) == 0, ((k / 64) % 2 == 0) ? 16'h7fff : 16'h8000, "R7");

    for (int k = 0; k < 3000; k++)
      cyc(($urandom % 2) != 0, ($urandom % 3) == 0,
          ($urandom % 2) ? 16'h7fff : 16'h8000, "R7");

    for (int k = 0; k < 2000; k++)
      cyc(($urandom % 4) != 0, ($urandom % 5) == 0, 16'($urandom), "R3");
    do_reset();
    checks++;
    if (code_out !== 2'b00) begin
      errors++;
      $display("FAIL R1: code_out after mid-run reset got %b expected 00", code_out);
    end
    for (int k = 0; k < 200; k++)
      cyc(1'b1, 1'b0, 16'h0, "R1");

    sat_hit = 0;
    for (int k = 0; k < 8192; k++) begin
      int sv;
      sv = $rtoi(16384.0 * $sin(2.0 * 3.14159265358979 * real'(k / 64) / 32.0));
      cyc(1'b1, (k % 64) == 0, 16'(sv), "R9");
    end
    checks++;
    if (sat_hit) begin
      errors++;
      $display("FAIL R9: integrator limit reached got 1 expected 0");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run incomplete got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule